// File: doc/BRIEF.md
# Extended segment sequence controller

This block sits next to an instruction pipeline and runs a short, self-expiring address override. When the decoder reports a begin-extended-sequence instruction, the block captures an 8-bit segment and a sequence length of one to four instructions. From the next instruction on, long and indirect data accesses form their 24-bit address from the stored segment (upper byte) and the 16-bit offset the pipeline supplies. Register-mode special-function-register accesses are steered to the extended register space. Interrupts, event-controller transfers and low-class traps are held off for the same span.

Each completion pulse from the pipeline uses up one instruction of the sequence. When the count runs out, the normal page-based address is passed through again, the standard register space returns and the lock drops. A high-priority trap ends the sequence at once. A fresh start while a sequence is running reloads both the count and the segment.

The length arrives already encoded as in the instruction's second byte. That byte carries a 2-bit field holding the length minus one, so codes 0 to 3 mean 1 to 4 instructions and an out-of-range length cannot occur. The start instruction changes no condition flag, and the block has no flag outputs.

Top module: `ext_seq_ctrl`

## Requirements
- R1: After reset the count is zero: `addr_o` equals `page_addr_i`, and `ext_sfr_o` and `lock_o` are 0.
- R2: A start accepted at a clock edge (with `len_code_i` = n-1) makes the block active in the cycle right after that edge. No idle cycle comes between them.
- R3: While active, `addr_o` equals {stored segment, `offset_i`}, with the segment in bits 23..16 and the offset in bits 15..0.
- R4: `ext_sfr_o` is 1 exactly while the block is active.
- R5: `lock_o` is 1 exactly while the block is active.
- R6: The count drops by one only at an edge where `instr_done_i` is 1. Edges without a pulse leave it unchanged, so the block stays active for exactly n completion pulses.
- R7: Once the count reaches zero, `addr_o` follows `page_addr_i` again and `ext_sfr_o` and `lock_o` return to 0.
- R8: While `hi_trap_i` is 1, the outputs take their normal values in that same cycle. The count is cleared at the next edge, so the block stays inactive after the trap drops.
- R9: A start while active reloads both the count and the segment. A completion pulse in the same cycle as a start is ignored.
- R10: A trap in the same cycle as a start wins, and no sequence begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin-sequence instruction decoded and accepted |
| seg_i | input | 8 | Segment value carried by the start instruction |
| len_code_i | input | 2 | Sequence length minus one |
| instr_done_i | input | 1 | One affected instruction has completed |
| offset_i | input | 16 | Long or indirect data offset |
| page_addr_i | input | 24 | Normal page-based data address |
| hi_trap_i | input | 1 | High-priority trap condition |
| addr_o | output | 24 | Resulting data address |
| ext_sfr_o | output | 1 | Select extended register space |
| lock_o | output | 1 | Hold off interrupts and low-class traps |

## Verification
State updates (load, decrement, clear) take effect one clock edge after the inputs that cause them. The outputs are combinational from that state and from the present `offset_i`, `page_addr_i` and `hi_trap_i`, so a trap or an offset change shows up in the same cycle. The bench drives inputs on the falling edge and checks a few nanoseconds later, before the next rising edge. Its expected count and segment are updated only at rising edges, which keeps a start visible exactly one cycle later and a trap visible at once.

// File: rtl/ext_seq_pkg.sv
package ext_seq_pkg;
    localparam int unsigned SEG_W_DEF  = 8;
    localparam int unsigned OFS_W_DEF  = 16;
    localparam int unsigned LEN_W_DEF  = 2;

    // Encoded length (value minus one) to the instruction count.
    function automatic int unsigned seq_len(input int unsigned code);
        return code + 1;
    endfunction
endpackage

// File: rtl/ext_seq_state.sv
module ext_seq_state #(
    parameter int unsigned SEG_W = ext_seq_pkg::SEG_W_DEF,
    parameter int unsigned LEN_W = ext_seq_pkg::LEN_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [SEG_W-1:0] seg_i,
    input  logic [LEN_W-1:0] len_code_i,
    input  logic             instr_done_i,
    input  logic             hi_trap_i,
    output logic             active_o,
    output logic [SEG_W-1:0] seg_o
);
    localparam int unsigned CNT_W = LEN_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEG_W-1:0] seg;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hi_trap_i) begin
            st_d.cnt = '0;
        end else if (start_i) begin
            st_d.cnt = {1'b0, len_code_i} + CNT_W'(1);
            st_d.seg = seg_i;
        end else if (instr_done_i && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = (st_q.cnt != '0) && !hi_trap_i;
    assign seg_o    = st_q.seg;
endmodule

// File: rtl/ext_seq_addr_mux.sv
module ext_seq_addr_mux #(
    parameter int unsigned SEG_W  = ext_seq_pkg::SEG_W_DEF,
    parameter int unsigned OFS_W  = ext_seq_pkg::OFS_W_DEF,
    parameter int unsigned ADDR_W = SEG_W + OFS_W
) (
    input  logic              sel_ext_i,
    input  logic [SEG_W-1:0]  seg_i,
    input  logic [OFS_W-1:0]  offset_i,
    input  logic [ADDR_W-1:0] page_addr_i,
    output logic [ADDR_W-1:0] addr_o
);
    always_comb begin
        if (sel_ext_i) begin
            addr_o = {seg_i, offset_i};
        end else begin
            addr_o = page_addr_i;
        end
    end
endmodule

// File: rtl/ext_seq_ctrl.sv
module ext_seq_ctrl #(
    parameter int unsigned SEG_W  = ext_seq_pkg::SEG_W_DEF,
    parameter int unsigned OFS_W  = ext_seq_pkg::OFS_W_DEF,
    parameter int unsigned LEN_W  = ext_seq_pkg::LEN_W_DEF,
    localparam int unsigned ADDR_W = SEG_W + OFS_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [SEG_W-1:0]  seg_i,
    input  logic [LEN_W-1:0]  len_code_i,
    input  logic              instr_done_i,
    input  logic [OFS_W-1:0]  offset_i,
    input  logic [ADDR_W-1:0] page_addr_i,
    input  logic              hi_trap_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              ext_sfr_o,
    output logic              lock_o
);
    logic             active;
    logic [SEG_W-1:0] seg_q;

    ext_seq_state #(.SEG_W(SEG_W), .LEN_W(LEN_W)) u_state (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (start_i),
        .seg_i        (seg_i),
        .len_code_i   (len_code_i),
        .instr_done_i (instr_done_i),
        .hi_trap_i    (hi_trap_i),
        .active_o     (active),
        .seg_o        (seg_q)
    );

    ext_seq_addr_mux #(.SEG_W(SEG_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_mux (
        .sel_ext_i   (active),
        .seg_i       (seg_q),
        .offset_i    (offset_i),
        .page_addr_i (page_addr_i),
        .addr_o      (addr_o)
    );

    assign ext_sfr_o = active;
    assign lock_o    = active;
endmodule

// File: rtl/ext_seq_ctrl_chk.sv
module ext_seq_ctrl_chk #(
    parameter int unsigned SEG_W  = 8,
    parameter int unsigned OFS_W  = 16,
    parameter int unsigned LEN_W  = 2,
    parameter int unsigned ADDR_W = SEG_W + OFS_W
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic [SEG_W-1:0]  seg_i,
    input logic [LEN_W-1:0]  len_code_i,
    input logic              instr_done_i,
    input logic [OFS_W-1:0]  offset_i,
    input logic [ADDR_W-1:0] page_addr_i,
    input logic              hi_trap_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              ext_sfr_o,
    input logic              lock_o
);
    // R2
    start_activates_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !hi_trap_i) |=> (lock_o || hi_trap_i));

    // R9
    seg_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !hi_trap_i) |=> (hi_trap_i || addr_o[ADDR_W-1:OFS_W] == $past(seg_i)));

    // R3
    offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ext_sfr_o |-> (addr_o[OFS_W-1:0] == offset_i));

    // R6
    hold_without_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ext_sfr_o && !instr_done_i) |=> (ext_sfr_o || hi_trap_i));

    // R7
    stays_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!lock_o && !start_i && !hi_trap_i) |=> !lock_o);

    // R8
    trap_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hi_trap_i |-> (!lock_o && !ext_sfr_o && addr_o == page_addr_i));

    // R10
    trap_beats_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && hi_trap_i) |=> !ext_sfr_o);
endmodule

bind ext_seq_ctrl ext_seq_ctrl_chk #(
    .SEG_W(SEG_W), .OFS_W(OFS_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/ext_seq_ctrl_tb.sv
module ext_seq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  seg = '0;
    logic [1:0]  len_code = '0;
    logic        done = 1'b0;
    logic [15:0] offset = '0;
    logic [23:0] page = '0;
    logic        trap = 1'b0;
    logic [23:0] addr;
    logic        ext_sfr;
    logic        lock;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // Expected state, advanced only at rising edges.
    int       ref_cnt = 0;
    bit [7:0] ref_seg = '0;

    always #10 clk = ~clk;

    ext_seq_ctrl u_dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .seg_i(seg),
        .len_code_i(len_code), .instr_done_i(done), .offset_i(offset),
        .page_addr_i(page), .hi_trap_i(trap), .addr_o(addr),
        .ext_sfr_o(ext_sfr), .lock_o(lock)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            ref_cnt <= 0;
            ref_seg <= '0;
        end else if (trap) begin
            ref_cnt <= 0;
        end else if (start) begin
            ref_cnt <= int'(len_code) + 1;
            ref_seg <= seg;
        end else if (done && ref_cnt != 0) begin
            ref_cnt <= ref_cnt - 1;
        end
    end

    function automatic bit exp_active();
        return (ref_cnt != 0) && !trap;
    endfunction

    function automatic logic [23:0] exp_addr();
        return exp_active() ? {ref_seg, offset} : page;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(input string ctx);
        chk(addr == exp_addr(), exp_active() ? {ctx, " R3"} : {ctx, " R7"}, 32'(addr), 32'(exp_addr()));
        chk(ext_sfr == exp_active(), {ctx, " R4"}, 32'(ext_sfr), 32'(exp_active()));
        chk(lock == exp_active(), {ctx, " R5"}, 32'(lock), 32'(exp_active()));
    endtask

    task automatic expect_lock(input bit exp, input string req);
        chk(lock == exp, req, 32'(lock), 32'(exp));
    endtask

    // Advance one cycle: drive on falling edge, check before next rising edge.
    task automatic step(input bit s, input bit [7:0] sg, input bit [1:0] lc, input bit d, input bit t);
        @(negedge clk);
        start = s; seg = sg; len_code = lc; done = d; trap = t;
        offset = 16'($urandom); page = 24'($urandom);
        #2;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset state
        chk(addr == page && !lock && !ext_sfr, "R1", 32'({lock, ext_sfr}), 32'(0));
        check_all("reset");

        // R2/R6: length 4, sparse completions
        step(1, 8'hA5, 2'd3, 0, 0); check_all("load");
        step(0, 8'h00, 2'd0, 0, 0); expect_lock(1, "R2 first cycle after start");
        check_all("R2");
        step(0, 8'h00, 2'd0, 1, 0); check_all("R6 d1");
        step(0, 8'h00, 2'd0, 0, 0); expect_lock(1, "R6 hold");
        step(0, 8'h00, 2'd0, 1, 0); check_all("R6 d2");
        step(0, 8'h00, 2'd0, 1, 0); check_all("R6 d3");
        step(0, 8'h00, 2'd0, 1, 0); expect_lock(1, "R6 before 4th pulse edge");
        chk(addr == {8'hA5, offset}, "R3 directed", 32'(addr), 32'({8'hA5, offset}));
        step(0, 8'h00, 2'd0, 0, 0); expect_lock(0, "R7 after 4 pulses");
        chk(addr == page, "R7 directed", 32'(addr), 32'(page));

        // Length 1
        step(1, 8'h3C, 2'd0, 0, 0);
        step(0, 8'h00, 2'd0, 1, 0); expect_lock(1, "R2 len1");
        step(0, 8'h00, 2'd0, 0, 0); expect_lock(0, "R7 len1");

        // R8: trap mid-sequence
        step(1, 8'h77, 2'd3, 0, 0);
        step(0, 8'h00, 2'd0, 0, 1); expect_lock(0, "R8 same cycle");
        chk(addr == page, "R8 addr", 32'(addr), 32'(page));
        step(0, 8'h00, 2'd0, 0, 0); expect_lock(0, "R8 cleared");

        // R9: reload while active; done beside start ignored
        step(1, 8'h11, 2'd1, 0, 0);
        step(0, 8'h00, 2'd0, 1, 0);
        step(1, 8'h22, 2'd1, 1, 0);
        step(0, 8'h00, 2'd0, 1, 0);
        chk(addr[23:16] == 8'h22, "R9 seg reload", 32'(addr[23:16]), 32'h22);
        step(0, 8'h00, 2'd0, 0, 0); expect_lock(1, "R9 count reload");
        step(0, 8'h00, 2'd0, 1, 0);
        step(0, 8'h00, 2'd0, 0, 0); expect_lock(0, "R9 end");

        // R10: trap with start
        step(1, 8'h99, 2'd2, 0, 1);
        step(0, 8'h00, 2'd0, 0, 0); expect_lock(0, "R10");

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 6) == 0, 8'($urandom), 2'($urandom), ($urandom % 2) == 0,
                 ($urandom % 40) == 0);
            check_all("rand");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule